// File: doc/BRIEF.md
# Parallel-to-Serial Line Transmitter with Loopback Parking and Transition Emphasis

This block takes a ten-bit code group and sends it out one bit at a time. The bit clock is modelled as a synchronous enable, `bit_en`, on the system clock. A full word takes ten enabled cycles. The lowest-indexed bit of each word leaves first. The next word is taken on the enabled cycle right after the last bit of the previous word, so words follow each other with no idle bits. The block raises `word_ready` while the next enabled cycle will capture `word_in`, which lets the source present words in step with the serializer.

The serial stream always appears on an internal loopback port, `loop_out`, which feeds a receiver. A mode input routes the stream in one of two ways:
- In normal mode the same stream also drives the external line `ser_out`.
- In loopback mode the external line is parked at logic 1 and only the internal port carries data.

A per-bit flag, `emph_out`, marks each bit whose value differs from the bit sent before it, so that a line driver can boost the transition. The comparison runs across word boundaries. The flag is active only when emphasis is enabled and the external line is actually carrying data.

Top module: `tx_serializer`

## Requirements
- R1: Bits of a captured word leave on successive enabled cycles in index order: `word_in[0]` first and `word_in[9]` last, one bit per enabled cycle.
- R2: `word_ready` is 1 after reset and again after the tenth bit of a word has been sent. The enabled cycle during which it is 1 captures `word_in`, and it then drops to 0 for the next nine enabled bits. There are no idle bits between words.
- R3: With `loop_en` = 0, `ser_out` equals the bit currently on `loop_out`. Both are registered, so a bit sent on an enabled edge appears on both outputs after that edge.
- R4: With `loop_en` = 1 on a clock edge, `ser_out` is 1 after that edge, whatever the data.
- R5: `loop_out` carries the serial stream in both modes. Changing `loop_en` neither interrupts nor shifts the stream.
- R6: With `emph_en` = 1 and `loop_en` = 0, `emph_out` is 1 exactly when the bit on `loop_out` differs from the bit sent before it. This includes the first bit of a word, which is compared with the last bit of the previous word. The bit before the first bit after reset counts as 0.
- R7: `emph_out` is 0 whenever `emph_en` = 0 or `loop_en` = 1 on the preceding edge.
- R8: A synchronous active-high `rst` gives `ser_out` = 0, `loop_out` = 0, `emph_out` = 0 and `word_ready` = 1 after the edge. The next word starts from bit 0.
- R9: On cycles with `bit_en` = 0 the stream does not advance: `loop_out` and `word_ready` hold their values. `word_in` is ignored unless both `word_ready` and `bit_en` are 1.
- R10: The positive-disparity comma group, with bits 0 to 6 equal to 0,0,1,1,1,1,1, leaves first bit first. `loop_out` therefore shows 0,0,1,1,1,1,1 on its first seven enabled bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-clock enable, one serial bit per enabled cycle |
| word_in | input | 10 | Parallel code group, bit 0 sent first |
| loop_en | input | 1 | 1 = loopback (external line parked at 1), 0 = normal |
| emph_en | input | 1 | 1 = emphasis flagging enabled |
| word_ready | output | 1 | Next enabled cycle captures `word_in` |
| ser_out | output | 1 | External serial line |
| loop_out | output | 1 | Internal loopback serial port toward the receiver |
| emph_out | output | 1 | Marks a bit that differs from the previous bit |

## Verification
Three things can coincide on one edge: a word capture at a word boundary, a transition flag that compares the new word's first bit with the old word's last bit, and a change of `loop_en` that reroutes the line. The bench sweeps all 1024 words back to back. It toggles loopback and emphasis on cycle-count periods that are unrelated to the word length, so mode switches land on boundary bits as well as mid-word bits. It runs a second pass with gaps in `bit_en`. On every cycle it judges the line, the loopback port, the flag and `word_ready` against a bit-index model of the stream.

// File: rtl/txs_pkg.sv
package txs_pkg;
  localparam int TXS_WORD_W = 10;

  typedef enum logic {
    LINE_DATA = 1'b0,
    LINE_PARK = 1'b1
  } line_mode_t;
endpackage

// File: rtl/txs_shift.sv
module txs_shift #(
  parameter int WORD_W = txs_pkg::TXS_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_in,
  output logic              word_ready,
  output logic              cur_bit
);
  localparam int CNT_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-2:0] rest_q;
  logic              ready_q;

  // bit served this cycle: fresh word bit 0 at a boundary, else the shifted remainder
  always_comb begin
    if (ready_q) cur_bit = word_in[0];
    else         cur_bit = rest_q[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rest_q  <= '0;
      ready_q <= 1'b1;
    end else if (bit_en) begin
      if (ready_q) rest_q <= word_in[WORD_W-1:1];
      else         rest_q <= rest_q >> 1;
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        ready_q <= 1'b1;
      end else begin
        cnt_q   <= cnt_q + 1'b1;
        ready_q <= 1'b0;
      end
    end
  end

  assign word_ready = ready_q;
endmodule

// File: rtl/txs_line.sv
module txs_line
  import txs_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic cur_bit,
  input  logic loop_en,
  output logic prev_bit,
  output logic next_bit,
  output logic ser_out,
  output logic loop_out
);
  line_mode_t mode;
  logic data_q;
  logic ser_q;

  assign mode     = loop_en ? LINE_PARK : LINE_DATA;
  assign next_bit = bit_en ? cur_bit : data_q;
  assign prev_bit = data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= 1'b0;
      ser_q  <= 1'b0;
    end else begin
      data_q <= next_bit;
      ser_q  <= (mode == LINE_PARK) ? 1'b1 : next_bit;
    end
  end

  assign loop_out = data_q;
  assign ser_out  = ser_q;
endmodule

// File: rtl/txs_emph.sv
module txs_emph (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic cur_bit,
  input  logic prev_bit,
  input  logic emph_en,
  input  logic loop_en,
  output logic emph_out
);
  logic flag_q;
  logic flag_nxt;
  logic emph_q;

  assign flag_nxt = bit_en ? (cur_bit ^ prev_bit) : flag_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      emph_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      emph_q <= emph_en & ~loop_en & flag_nxt;
    end
  end

  assign emph_out = emph_q;
endmodule

// File: rtl/tx_serializer.sv
module tx_serializer #(
  parameter int WORD_W = txs_pkg::TXS_WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [WORD_W-1:0] word_in,
  input  logic              loop_en,
  input  logic              emph_en,
  output logic              word_ready,
  output logic              ser_out,
  output logic              loop_out,
  output logic              emph_out
);
  logic cur_bit;
  logic prev_bit;
  logic next_bit;

  txs_shift #(.WORD_W(WORD_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .bit_en     (bit_en),
    .word_in    (word_in),
    .word_ready (word_ready),
    .cur_bit    (cur_bit)
  );

  txs_line u_line (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .cur_bit  (cur_bit),
    .loop_en  (loop_en),
    .prev_bit (prev_bit),
    .next_bit (next_bit),
    .ser_out  (ser_out),
    .loop_out (loop_out)
  );

  txs_emph u_emph (
    .clk      (clk),
    .rst      (rst),
    .bit_en   (bit_en),
    .cur_bit  (cur_bit),
    .prev_bit (prev_bit),
    .emph_en  (emph_en),
    .loop_en  (loop_en),
    .emph_out (emph_out)
  );
endmodule

// File: rtl/tx_serializer_chk.sv
module tx_serializer_chk (
  input logic clk,
  input logic rst,
  input logic bit_en,
  input logic loop_en,
  input logic emph_en,
  input logic word_ready,
  input logic ser_out,
  input logic loop_out,
  input logic emph_out
);
  p_park_high_r4: assert property (@(posedge clk) disable iff (rst)
    loop_en |=> ser_out);

  p_line_follows_r3: assert property (@(posedge clk) disable iff (rst)
    !loop_en |=> (ser_out == loop_out));

  p_emph_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    (!emph_en || loop_en) |=> !emph_out);

  p_emph_edge_r6: assert property (@(posedge clk) disable iff (rst)
    (emph_en && !loop_en && bit_en) |=> (emph_out == (loop_out != $past(loop_out))));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> ($stable(loop_out) && $stable(word_ready)));

  p_capture_r2: assert property (@(posedge clk) disable iff (rst)
    (word_ready && bit_en) |=> !word_ready);
endmodule

bind tx_serializer tx_serializer_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .loop_en    (loop_en),
  .emph_en    (emph_en),
  .word_ready (word_ready),
  .ser_out    (ser_out),
  .loop_out   (loop_out),
  .emph_out   (emph_out)
);

// File: tb/sim_tx_serializer.sv
module sim_tx_serializer;
  localparam int W = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic [W-1:0] word_in = '0;
  logic loop_en = 1'b0;
  logic emph_en = 1'b0;
  logic word_ready, ser_out, loop_out, emph_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // bench model of the stream
  logic [W-1:0] cur_w;
  int   idx_m;
  logic prev_m;
  logic flag_m;

  always #10 clk = ~clk;

  tx_serializer #(.WORD_W(W)) u0 (
    .clk(clk), .rst(rst), .bit_en(bit_en), .word_in(word_in),
    .loop_en(loop_en), .emph_en(emph_en), .word_ready(word_ready),
    .ser_out(ser_out), .loop_out(loop_out), .emph_out(emph_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %b expected %b", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    idx_m = 0; prev_m = 1'b0; flag_m = 1'b0; cur_w = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bit_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R8: state right after reset
    chk("R8 ser_out",    ser_out,    1'b0);
    chk("R8 loop_out",   loop_out,   1'b0);
    chk("R8 emph_out",   emph_out,   1'b0);
    chk("R8 word_ready", word_ready, 1'b1);
  endtask

  // drive at negedge (caller is there), advance model, check at the next negedge
  task automatic step(input logic be, input logic lp, input logic em,
                      input logic [W-1:0] w, output logic captured);
    logic b;
    captured = 1'b0;
    chk("R2 word_ready", word_ready, (idx_m == 0));
    bit_en = be; loop_en = lp; emph_en = em;
    word_in = (idx_m == 0) ? w : ~w;   // R9: off-boundary words must be ignored
    if (be) begin
      if (idx_m == 0) begin cur_w = w; captured = 1'b1; end
      b = cur_w[idx_m];
      flag_m = (b != prev_m);
      prev_m = b;
      idx_m = (idx_m + 1) % W;
    end
    @(negedge clk);
    cyc++;
    chk("R1/R5/R9 loop_out", loop_out, prev_m);
    chk(lp ? "R4 ser_out parked" : "R3 ser_out", ser_out, lp ? 1'b1 : prev_m);
    chk((em && !lp) ? "R6 emph_out" : "R7 emph_out", emph_out, em & ~lp & flag_m);
  endtask

  task automatic sweep(input bit gaps);
    int w;
    logic cap;
    w = 0;
    while (w < 1024 + 1) begin
      step(gaps ? ((cyc % 4) != 3) : 1'b1,
           ((cyc / 7) % 5) == 0,
           ((cyc / 13) % 3) != 0,
           W'(w), cap);
      if (cap) w++;
    end
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic cap;
    logic [6:0] seen;
    model_reset();
    do_reset();
    // R10: comma group, bits 0..6 = 0,0,1,1,1,1,1
    for (int i = 0; i < W; i++) begin
      step(1'b1, 1'b0, 1'b1, 10'b0101111100, cap);
      if (i < 7) seen[i] = loop_out;
    end
    checks++;
    if (seen !== 7'b1111100) begin
      errors++;
      $display("FAIL R10 comma order actual %b expected %b", seen, 7'b1111100);
    end
    // R1/R2/R6: back-to-back sweep of every word, full-rate bit clock
    sweep(1'b0);
    // R8: reset mid-word, then R9 sweep with gaps in the bit clock
    step(1'b1, 1'b0, 1'b0, 10'h3A5, cap);
    step(1'b1, 1'b0, 1'b0, 10'h3A5, cap);
    do_reset();
    sweep(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule